// File: doc/BRIEF.md
# UART Interrupt Enable and Request Logic

This block holds the interrupt enable register of a UART with a 128-byte receive FIFO. From the line status, modem, flow-control and enable state it forms one active-high interrupt request. The host writes the enable register over a simple strobe-and-data register bus and can read it back. Line status conditions are overrun and three per-character error flags: parity, framing and break. The other sources are a modem-status change level, a received-Xoff event, the level of the UART's own RTS output and the asynchronous CTS input. The sleep-enable bit is passed to the power logic as an output.

The upper half of the enable register (sleep, Xoff, RTS and CTS) is active only while the enhanced-features input is high. The per-character errors can be reported in one of two ways. In the default mode they are reported while the bad character sits at the head of the receive FIFO. In the early mode, selected by an error-mode input, they are reported as soon as the bad character is pushed into the FIFO, and are then held until the host reads the line status. Every interrupt source, whether held or momentary, is seen by the request output one clock after the source appears. Sticky flow-control flags are cleared by the host through a clear strobe.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, and `irq` and `sleep_en` are low.
- R2: A write (`reg_wr` high) always loads bits 3:0 of the enable register from `reg_wdata[3:0]`. Those bits read back on `reg_rdata[3:0]` from the next cycle. Bits 1:0 are stored and read back only.
- R3: Bits 7:4 are loaded only when `enh_en` is 1 during the write. While `enh_en` is 0, `reg_rdata[7:4]` reads 0 and `sleep_en` is low, and the stored bits reappear when `enh_en` returns to 1. `sleep_en` follows bit 4 while `enh_en` is 1.
- R4: With bit 2 set, an `ovr_evt` pulse raises `irq` on the next clock. The overrun stays pending until an `lsr_rd` strobe, and `irq` drops one clock after the clearing edge.
- R5: With `err_mode`=0 and bit 2 set, `irq` follows any set bit of `head_err` (bit 0 parity, bit 1 framing, bit 2 break) with a delay of one clock.
- R6: With `err_mode`=1 and bit 2 set, a push (`rx_push`) with any bit of `rx_push_err` set raises `irq` on the next clock and holds it until `lsr_rd`. In this mode `head_err` has no effect.
- R7: With bit 3 set, `irq` follows `modem_delta` with a delay of one clock.
- R8: With `enh_en`=1 and bit 5 set, an `xoff_evt` pulse raises `irq` on the next clock and sets a sticky flag. The flag is cleared by `flow_clr[0]`.
- R9: With `enh_en`=1 and bit 6 set, a low-to-high change of `rts_lvl` raises `irq` on the next clock and sets a sticky flag, which is cleared by `flow_clr[1]`. A high-to-low change raises nothing.
- R10: With `enh_en`=1 and bit 7 set, a rising `cts_in` passes a two-flop synchroniser. `irq` rises on the third clock edge after the change, and the sticky flag is cleared by `flow_clr[2]`. A falling `cts_in` raises nothing.
- R11: If a sticky flag is set and cleared in the same cycle, the set takes priority.
- R12: `irq` is a register. Its value is the OR of each enabled source's condition as it stood one clock earlier.
- R13: A source whose enable bit is 0, or is not in effect because `enh_en` is 0, never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Enable register write strobe |
| reg_wdata | input | 8 | Enable register write data |
| reg_rdata | output | 8 | Effective enable register value |
| lsr_rd | input | 1 | Host line status read strobe |
| ovr_evt | input | 1 | Receive overrun pulse |
| head_err | input | 3 | Error flags of the character at the FIFO head |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_push_err | input | 3 | Error flags of the character being pushed |
| modem_delta | input | 1 | Modem status change pending level |
| xoff_evt | input | 1 | Received Xoff character pulse |
| rts_lvl | input | 1 | Level of the RTS output |
| cts_in | input | 1 | Asynchronous CTS input |
| flow_clr | input | 3 | Clear strobes: bit 0 Xoff, bit 1 RTS, bit 2 CTS |
| enh_en | input | 1 | Enhanced-features gate |
| err_mode | input | 1 | 1 = report character errors on push |
| irq | output | 1 | Interrupt request, active high |
| sleep_en | output | 1 | Sleep mode enable |

## Verification
The bound checker verifies register-level facts on every cycle. Writes load the low nibble and, while enhanced features are on, the high nibble. Sleep is never enabled while enhanced features are off. An enabled overrun, Xoff or modem change always produces a request on the next clock, and a request never appears without an effective enable bit in the previous cycle. The bench's scenarios are needed for the behaviours that span several cycles: the three-edge CTS latency, rising-only edge detection, the hold-until-read of early-mode errors, set-over-clear priority, and the stored upper bits returning when enhanced features are turned back on.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the UART interrupt enable block: the layout of the
// enable register, the width of the error flags and the flow-control clear lanes.
package uart_irq_pkg;
    localparam int IER_W      = 8;
    localparam int ENH_LO     = 4;   // first bit gated by enh_en
    localparam int B_LINE     = 2;
    localparam int B_MODEM    = 3;
    localparam int B_SLEEP    = 4;
    localparam int B_XOFF     = 5;
    localparam int B_RTS      = 6;
    localparam int B_CTS      = 7;
    localparam int ERR_W      = 3;   // parity, framing, break
    localparam int FLOW_N     = 3;
    localparam int CLR_XOFF   = 0;
    localparam int CLR_RTS    = 1;
    localparam int CLR_CTS    = 2;
    localparam int CTS_SYNC_N = 2;
endpackage

// File: rtl/uart_irq_enreg.sv
`timescale 1ns/1ps
// Enable register. Bits below LO_BITS are written on every write. Upper bits
// are written only while enh_en is high. The effective value shows the upper
// bits as zero while enh_en is low; the stored upper bits are kept.
// Assumes the write strobe is a single-cycle pulse synchronous to clk.
module uart_irq_enreg #(
    parameter int W       = 8,
    parameter int LO_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         enh_en,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] LO_MASK = W'((1 << LO_BITS) - 1);

    logic [W-1:0] stored;
    logic [W-1:0] wmask;

    // Select which bits this write may change.
    always_comb wmask = enh_en ? {W{1'b1}} : LO_MASK;

    // Load the allowed bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored <= '0;
        else if (wr)
            stored <= (stored & ~wmask) | (wdata & wmask);
    end

    // Hide the gated bits while enhanced features are off.
    always_comb eff = enh_en ? stored : (stored & LO_MASK);
endmodule

// File: rtl/uart_irq_linestat.sv
`timescale 1ns/1ps
// Line status condition. Overrun is reported in its own cycle and held until
// a status read. Character errors follow the FIFO head in mode 0, or are
// caught on push and held until a status read in mode 1.
// Assumes ovr_evt and rx_push are single-cycle pulses.
module uart_irq_linestat #(
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ovr_evt,
    input  logic [EW-1:0] head_err,
    input  logic          rx_push,
    input  logic [EW-1:0] rx_push_err,
    input  logic          err_mode,
    input  logic          lsr_rd,
    output logic          cond
);
    logic ovr_pend;
    logic err_pend;
    logic push_bad;

    // Flag a pushed character that carries any error.
    always_comb push_bad = rx_push & (|rx_push_err);

    // Hold the overrun until the host reads status; a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_pend <= 1'b0;
        else
            ovr_pend <= ovr_evt | (ovr_pend & ~lsr_rd);
    end

    // Hold an early-mode character error until the host reads status.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_pend <= 1'b0;
        else
            err_pend <= (err_mode & push_bad) | (err_pend & ~lsr_rd);
    end

    // Combine overrun with the error source the mode selects.
    always_comb begin
        cond = ovr_evt | ovr_pend;
        if (err_mode)
            cond = cond | err_pend | push_bad;
        else
            cond = cond | (|head_err);
    end
endmodule

// File: rtl/uart_irq_pend.sv
`timescale 1ns/1ps
// Sticky pending source. An optional synchroniser of SYNC_N flops comes first.
// RISE=1 sets the flag on a low-to-high change; RISE=0 treats the input as a
// pulse. The condition covers the setting event itself and the held flag.
// A set and a clear in the same cycle leave the flag set.
module uart_irq_pend #(
    parameter int SYNC_N = 0,
    parameter bit RISE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic clr,
    output logic cond
);
    logic sig_s;
    logic set;
    logic pend;

    generate
        if (SYNC_N > 0) begin : g_sync
            logic [SYNC_N-1:0] stage;
            // Shift the asynchronous input through the synchroniser.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage <= '0;
                else begin
                    stage[0] <= sig_in;
                    for (int k = 1; k < SYNC_N; k++)
                        stage[k] <= stage[k-1];
                end
            end
            assign sig_s = stage[SYNC_N-1];
        end else begin : g_nosync
            assign sig_s = sig_in;
        end

        if (RISE) begin : g_rise
            logic prev;
            // Remember last cycle's level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prev <= 1'b0;
                else
                    prev <= sig_s;
            end
            assign set = sig_s & ~prev;
        end else begin : g_pulse
            assign set = sig_s;
        end
    endgenerate

    // Keep the flag until cleared; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else
            pend <= set | (pend & ~clr);
    end

    // Report the event in its own cycle as well as while it is held.
    always_comb cond = set | pend;
endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
// UART interrupt enable and request top. Gates each source with its effective
// enable bit and registers the OR as the interrupt request. Assumes all host
// strobes are synchronous single-cycle pulses; cts_in may be asynchronous.
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [IER_W-1:0] reg_wdata,
    output logic [IER_W-1:0] reg_rdata,
    input  logic             lsr_rd,
    input  logic             ovr_evt,
    input  logic [ERR_W-1:0] head_err,
    input  logic             rx_push,
    input  logic [ERR_W-1:0] rx_push_err,
    input  logic             modem_delta,
    input  logic             xoff_evt,
    input  logic             rts_lvl,
    input  logic             cts_in,
    input  logic [FLOW_N-1:0] flow_clr,
    input  logic             enh_en,
    input  logic             err_mode,
    output logic             irq,
    output logic             sleep_en
);
    logic [IER_W-1:0] en;
    logic line_c, xoff_c, rts_c, cts_c;
    logic irq_d;

    uart_irq_enreg #(.W(IER_W), .LO_BITS(ENH_LO)) u_enreg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .enh_en(enh_en), .eff(en)
    );

    uart_irq_linestat #(.EW(ERR_W)) u_line (
        .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .head_err(head_err),
        .rx_push(rx_push), .rx_push_err(rx_push_err), .err_mode(err_mode),
        .lsr_rd(lsr_rd), .cond(line_c)
    );

    uart_irq_pend #(.SYNC_N(0), .RISE(1'b0)) u_xoff (
        .clk(clk), .rst_n(rst_n), .sig_in(xoff_evt),
        .clr(flow_clr[CLR_XOFF]), .cond(xoff_c)
    );

    uart_irq_pend #(.SYNC_N(0), .RISE(1'b1)) u_rts (
        .clk(clk), .rst_n(rst_n), .sig_in(rts_lvl),
        .clr(flow_clr[CLR_RTS]), .cond(rts_c)
    );

    uart_irq_pend #(.SYNC_N(CTS_SYNC_N), .RISE(1'b1)) u_cts (
        .clk(clk), .rst_n(rst_n), .sig_in(cts_in),
        .clr(flow_clr[CLR_CTS]), .cond(cts_c)
    );

    // Gate each source with its effective enable bit.
    always_comb
        irq_d = (en[B_LINE]  & line_c)
              | (en[B_MODEM] & modem_delta)
              | (en[B_XOFF]  & xoff_c)
              | (en[B_RTS]   & rts_c)
              | (en[B_CTS]   & cts_c);

    // Register the request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= irq_d;
    end

    // Present the readback and the sleep enable.
    always_comb begin
        reg_rdata = en;
        sleep_en  = en[B_SLEEP];
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for uart_irq_ctrl, attached through bind; watches ports only.
module uart_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ovr_evt,
    input logic       modem_delta,
    input logic       xoff_evt,
    input logic       enh_en,
    input logic       irq,
    input logic       sleep_en
);
    // R2
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[3:0] == $past(reg_wdata[3:0]));

    // R3
    high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && enh_en) |=> (!enh_en || reg_rdata[7:4] == $past(reg_wdata[7:4])));

    // R3
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en |-> !sleep_en);

    // R4
    overrun_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && reg_rdata[2]) |=> irq);

    // R7
    modem_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_delta && reg_rdata[3]) |=> irq);

    // R8
    xoff_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xoff_evt && reg_rdata[5]) |=> irq);

    // R13
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && irq) |-> ($past(reg_rdata & 8'hEC) != 8'h00));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovr_evt(ovr_evt), .modem_delta(modem_delta),
    .xoff_evt(xoff_evt), .enh_en(enh_en), .irq(irq), .sleep_en(sleep_en)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
// Bench for uart_irq_ctrl: a behavioural reference model is compared on
// every cycle, and directed checks cover latencies and corner cases.
module uart_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lsr_rd = 1'b0;
    logic       ovr_evt = 1'b0;
    logic [2:0] head_err = 3'b000;
    logic       rx_push = 1'b0;
    logic [2:0] rx_push_err = 3'b000;
    logic       modem_delta = 1'b0;
    logic       xoff_evt = 1'b0;
    logic       rts_lvl = 1'b0;
    logic       cts_in = 1'b0;
    logic [2:0] flow_clr = 3'b000;
    logic       enh_en = 1'b0;
    logic       err_mode = 1'b0;
    logic       irq;
    logic       sleep_en;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lsr_rd(lsr_rd), .ovr_evt(ovr_evt),
        .head_err(head_err), .rx_push(rx_push), .rx_push_err(rx_push_err),
        .modem_delta(modem_delta), .xoff_evt(xoff_evt), .rts_lvl(rts_lvl),
        .cts_in(cts_in), .flow_clr(flow_clr), .enh_en(enh_en),
        .err_mode(err_mode), .irq(irq), .sleep_en(sleep_en)
    );

    // Reference model state.
    bit [7:0] m_ier;
    bit m_irq, m_ovr, m_err, m_xoff, m_rtsp, m_ctsp, m_rts_prev;
    bit cts_pipe[$] = '{1'b0, 1'b0, 1'b0};   // sync1, sync2, previous

    always @(posedge clk) begin
        bit [7:0] eff;
        bit rts_rise, cts_rise, push_bad, line;
        if (!rst_n) begin
            m_ier = 0; m_irq = 0; m_ovr = 0; m_err = 0;
            m_xoff = 0; m_rtsp = 0; m_ctsp = 0; m_rts_prev = 0;
            cts_pipe = '{1'b0, 1'b0, 1'b0};
        end else begin
            eff = m_ier;
            if (!enh_en) eff[7:4] = 4'h0;
            rts_rise = rts_lvl && !m_rts_prev;
            cts_rise = cts_pipe[1] && !cts_pipe[2];
            push_bad = rx_push && (rx_push_err != 0);
            line = ovr_evt || m_ovr ||
                   (err_mode ? (m_err || push_bad) : (head_err != 0));
            m_irq = (eff[2] && line) || (eff[3] && modem_delta) ||
                    (eff[5] && (xoff_evt || m_xoff)) ||
                    (eff[6] && (rts_rise || m_rtsp)) ||
                    (eff[7] && (cts_rise || m_ctsp));
            m_ovr  = ovr_evt || (m_ovr && !lsr_rd);
            m_err  = (err_mode && push_bad) || (m_err && !lsr_rd);
            m_xoff = xoff_evt || (m_xoff && !flow_clr[0]);
            m_rtsp = rts_rise || (m_rtsp && !flow_clr[1]);
            m_ctsp = cts_rise || (m_ctsp && !flow_clr[2]);
            m_rts_prev = rts_lvl;
            cts_pipe.push_front(cts_in);
            void'(cts_pipe.pop_back());
            if (reg_wr) begin
                m_ier[3:0] = reg_wdata[3:0];
                if (enh_en) m_ier[7:4] = reg_wdata[7:4];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare with the model on every cycle, after inputs have settled.
    always @(negedge clk) begin
        #1;
        if (!done) begin
            chk(cur_req, {31'b0, irq}, {31'b0, m_irq});
            chk(cur_req, {31'b0, sleep_en}, {31'b0, m_ier[4] && enh_en});
            chk(cur_req, {24'b0, reg_rdata},
                {24'b0, enh_en ? m_ier : {4'h0, m_ier[3:0]}});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ier(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); lsr_rd = 1'b1; flow_clr = 3'b111;
        @(negedge clk); lsr_rd = 1'b0; flow_clr = 3'b000;
        tick(2);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        // R1 reset state
        tick(3); rst_n = 1'b1; tick(1);
        chk("R1", {24'b0, reg_rdata}, 32'h00);
        chk("R1", {31'b0, irq}, 0);
        chk("R1", {31'b0, sleep_en}, 0);

        // R2 low nibble writes
        cur_req = "R2";
        wr_ier(8'h0F); tick(1);
        chk("R2", {24'b0, reg_rdata}, 32'h0F);
        wr_ier(8'h03); tick(1);
        chk("R2", {24'b0, reg_rdata}, 32'h03);

        // R3 enhanced gating of the upper bits
        cur_req = "R3";
        wr_ier(8'hF0); tick(1);
        chk("R3", {24'b0, reg_rdata}, 32'h00);
        chk("R3", {31'b0, sleep_en}, 0);
        @(negedge clk); enh_en = 1'b1; #2;
        chk("R3", {24'b0, reg_rdata}, 32'h00);
        wr_ier(8'h10); tick(1);
        chk("R3", {31'b0, sleep_en}, 1);
        @(negedge clk); enh_en = 1'b0; #2;
        chk("R3", {31'b0, sleep_en}, 0);
        chk("R3", {24'b0, reg_rdata}, 32'h00);
        @(negedge clk); enh_en = 1'b1; #2;
        chk("R3", {24'b0, reg_rdata}, 32'h10);

        // R4 / R12 overrun: next-cycle request, held until status read
        cur_req = "R4";
        wr_ier(8'h04);
        @(negedge clk); ovr_evt = 1'b1;
        @(negedge clk); ovr_evt = 1'b0;
        chk("R12", {31'b0, irq}, 1);
        tick(3);
        chk("R4", {31'b0, irq}, 1);
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
        chk("R4", {31'b0, irq}, 1);
        tick(1);
        chk("R4", {31'b0, irq}, 0);

        // R5 head-of-FIFO errors, default mode
        cur_req = "R5";
        for (int b = 0; b < 3; b++) begin
            @(negedge clk); head_err = 3'(1 << b);
            tick(1);
            chk("R5", {31'b0, irq}, 1);
            head_err = 3'b000;
            tick(1);
            chk("R5", {31'b0, irq}, 0);
        end

        // R6 early error mode
        cur_req = "R6";
        @(negedge clk); err_mode = 1'b1; head_err = 3'b111;
        tick(2);
        chk("R6", {31'b0, irq}, 0);
        @(negedge clk); head_err = 3'b000; rx_push = 1'b1; rx_push_err = 3'b000;
        @(negedge clk); rx_push_err = 3'b010;
        @(negedge clk); rx_push = 1'b0; rx_push_err = 3'b000;
        chk("R6", {31'b0, irq}, 1);
        tick(4);
        chk("R6", {31'b0, irq}, 1);
        clear_all();
        chk("R6", {31'b0, irq}, 0);
        @(negedge clk); err_mode = 1'b0;

        // R7 modem status
        cur_req = "R7";
        wr_ier(8'h08);
        @(negedge clk); modem_delta = 1'b1;
        tick(1);
        chk("R7", {31'b0, irq}, 1);
        modem_delta = 1'b0;
        tick(1);
        chk("R7", {31'b0, irq}, 0);

        // R8 Xoff, and R13 while enhanced features are off
        cur_req = "R13";
        @(negedge clk); enh_en = 1'b0;
        wr_ier(8'hE0);
        @(negedge clk); xoff_evt = 1'b1;
        @(negedge clk); xoff_evt = 1'b0;
        tick(1);
        chk("R13", {31'b0, irq}, 0);
        clear_all();
        cur_req = "R8";
        @(negedge clk); enh_en = 1'b1;
        wr_ier(8'h20);
        @(negedge clk); xoff_evt = 1'b1;
        @(negedge clk); xoff_evt = 1'b0;
        chk("R8", {31'b0, irq}, 1);
        tick(3);
        chk("R8", {31'b0, irq}, 1);
        clear_all();
        chk("R8", {31'b0, irq}, 0);

        // R11 set wins over clear in the same cycle
        cur_req = "R11";
        @(negedge clk); xoff_evt = 1'b1; flow_clr = 3'b001;
        @(negedge clk); xoff_evt = 1'b0; flow_clr = 3'b000;
        tick(3);
        chk("R11", {31'b0, irq}, 1);
        clear_all();

        // R9 RTS rising edge only
        cur_req = "R9";
        wr_ier(8'h40);
        @(negedge clk); rts_lvl = 1'b1;
        tick(1);
        chk("R9", {31'b0, irq}, 1);
        clear_all();
        @(negedge clk); rts_lvl = 1'b0;
        tick(3);
        chk("R9", {31'b0, irq}, 0);

        // R10 CTS through the synchroniser
        cur_req = "R10";
        wr_ier(8'h80);
        @(negedge clk); cts_in = 1'b1;
        tick(2);
        chk("R10", {31'b0, irq}, 0);
        tick(1);
        chk("R10", {31'b0, irq}, 1);
        clear_all();
        chk("R10", {31'b0, irq}, 0);
        @(negedge clk); cts_in = 1'b0;
        tick(5);
        chk("R10", {31'b0, irq}, 0);

        // R13 all sources active with every enable cleared
        cur_req = "R13";
        wr_ier(8'h00);
        @(negedge clk); ovr_evt = 1'b1; modem_delta = 1'b1; xoff_evt = 1'b1;
        rts_lvl = 1'b1; cts_in = 1'b1; head_err = 3'b100;
        @(negedge clk); ovr_evt = 1'b0; xoff_evt = 1'b0;
        tick(5);
        chk("R13", {31'b0, irq}, 0);
        @(negedge clk); modem_delta = 1'b0; head_err = 3'b000;
        tick(2);
        finish_run();
    end
endmodule